// File: doc/BRIEF.md
# Serial Output Register Controller with Hardware Clear

This block drives an external 8-bit serial-in, parallel-out register that has a shift stage and a separate storage stage. It generates four pins: a serial data bit, a shift clock, a storage (latch) clock and an active-low clear for the shift stage. Two commands are supported. A load command shifts a word out and then latches it. A clear command pulses the clear pin and then latches, so the outputs go to zero without any bits being shifted.

A raw push-button input passes through a synchronizer and a stability filter. Each accepted press alternates between issuing a clear and issuing an all-ones load, and the first press after reset issues a clear. Every high or low step on the pin outputs lasts a configurable number of system clocks, so the external part's minimum pulse widths are met. A busy flag covers each sequence. While it is set, strobes and presses are dropped.

Top module: `sr_clear_driver`

## Requirements
- R1: After reset, busy is 0, the latch and clear pins are high, and the shift clock and serial data pins are low.
- R2: A load sequence drives the latch pin low, then sends WIDTH bits most significant bit first. Each bit is placed on the serial pin while the shift clock is low and then held through one shift-clock high phase. The latch pin then returns high, and the external storage stage shows the word.
- R3: A clear sequence runs in this order: clear pin low, clear pin high, latch pin low, latch pin high. It produces no shift clock edge, the serial pin stays low, and the storage stage then reads all zeros.
- R4: While the clear pin is low, the external shift stage is already zero, but the storage outputs keep their previous value until the latch pin rises.
- R5: Each shift-clock high phase and each clear-pin low phase lasts exactly PHASE_CYC system clocks.
- R6: A new button level is accepted only after it has been stable for DEB_CYC clocks. A bounce shorter than that produces no command.
- R7: Only the released-to-pressed transition of the filtered button issues a command. Accepted presses alternate clear, all-ones load, clear, and so on, starting with a clear after reset.
- R8: Busy rises on the clock after a command is accepted and stays high until the sequence ends. Strobes and button presses seen while busy is high are dropped, and a dropped press does not advance the alternation of R7.
- R9: When strobes arrive in the same idle cycle, the clear strobe wins over the load strobe, and both win over a button press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Unfiltered push-button level, 1 = pressed |
| upd_req | input | 1 | One-cycle strobe requesting a load of upd_word |
| clr_req | input | 1 | One-cycle strobe requesting a hardware clear |
| upd_word | input | WIDTH | Word to send on a load strobe |
| busy | output | 1 | High while a sequence runs |
| ser_out | output | 1 | Serial data to the external register |
| shclk_out | output | 1 | Shift clock, idles low |
| latch_out | output | 1 | Storage clock, idles high, loads on its rising edge |
| clr_n_out | output | 1 | Active-low shift-stage clear, idles high |

## Verification
The load strobe and the clear strobe can land in the same idle cycle. A button press can also coincide with a strobe. The bench raises both strobes on the same clock, together with a word of all ones, and judges the result at the modeled external register: the storage must read zero, and no shift clock edge may have occurred. A further case raises a clear strobe in the middle of a running load. It checks that no clear pulse appears and that the loaded word survives.

// File: rtl/sr_drv_pkg.sv
package sr_drv_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_U_LATLO,
    ST_U_SETUP,
    ST_U_SHHI,
    ST_U_TAIL,
    ST_C_CLRLO,
    ST_C_CLRHI,
    ST_C_LATLO,
    ST_LATHI
  } seq_state_e;

  typedef struct packed {
    logic ser;
    logic shclk;
    logic latch;
    logic clr_n;
  } pin_set_t;

  localparam pin_set_t PINS_IDLE = '{ser: 1'b0, shclk: 1'b0, latch: 1'b1, clr_n: 1'b1};

  // Pin levels that belong to each step; data_bit is the bit in flight.
  function automatic pin_set_t decode_pins(seq_state_e st, logic data_bit);
    pin_set_t p;
    p = PINS_IDLE;
    case (st)
      ST_U_LATLO: p.latch = 1'b0;
      ST_U_SETUP: begin
        p.latch = 1'b0;
        p.ser   = data_bit;
      end
      ST_U_SHHI: begin
        p.latch = 1'b0;
        p.ser   = data_bit;
        p.shclk = 1'b1;
      end
      ST_U_TAIL:  p.latch = 1'b0;
      ST_C_CLRLO: p.clr_n = 1'b0;
      ST_C_LATLO: p.latch = 1'b0;
      default:    p = PINS_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sr_debounce.sv
module sr_debounce #(
  parameter int DEB_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic press_pulse
);
  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYC - 1);

  logic [1:0]    sync_q;
  logic          stable_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= '0;
      stable_q    <= 1'b0;
      cnt_q       <= '0;
      press_pulse <= 1'b0;
    end else begin
      sync_q      <= {sync_q[0], raw_in};
      press_pulse <= 1'b0;
      if (sync_q[1] == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q       <= '0;
        stable_q    <= sync_q[1];
        press_pulse <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sr_phase_timer.sv
module sr_phase_timer #(
  parameter int PHASE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic phase_end
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign phase_end = (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || hold || phase_end) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
  import sr_drv_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int PHASE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_upd,
  input  logic             go_clr,
  input  logic [WIDTH-1:0] word_in,
  output pin_set_t         pins,
  output logic             busy
);
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [BW-1:0] BIT_TOP = BW'(WIDTH - 1);

  seq_state_e     state_q, state_d;
  logic [BW-1:0]  bit_q, bit_d;
  logic [WIDTH-1:0] word_q, word_d;
  logic           phase_end;

  sr_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .hold     (state_q == ST_IDLE),
    .phase_end(phase_end)
  );

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    word_d  = word_q;
    case (state_q)
      ST_IDLE: begin
        if (go_clr) begin
          state_d = ST_C_CLRLO;
        end else if (go_upd) begin
          state_d = ST_U_LATLO;
          word_d  = word_in;
          bit_d   = BIT_TOP;
        end
      end
      ST_U_LATLO: if (phase_end) state_d = ST_U_SETUP;
      ST_U_SETUP: if (phase_end) state_d = ST_U_SHHI;
      ST_U_SHHI: begin
        if (phase_end) begin
          if (bit_q == '0) begin
            state_d = ST_U_TAIL;
          end else begin
            state_d = ST_U_SETUP;
            bit_d   = bit_q - 1'b1;
          end
        end
      end
      ST_U_TAIL:  if (phase_end) state_d = ST_LATHI;
      ST_C_CLRLO: if (phase_end) state_d = ST_C_CLRHI;
      ST_C_CLRHI: if (phase_end) state_d = ST_C_LATLO;
      ST_C_LATLO: if (phase_end) state_d = ST_LATHI;
      ST_LATHI:   if (phase_end) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      word_q  <= '0;
      pins    <= PINS_IDLE;
      busy    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      word_q  <= word_d;
      pins    <= decode_pins(state_d, word_d[bit_d]);
      busy    <= (state_d != ST_IDLE);
    end
  end
endmodule

// File: rtl/sr_clear_driver.sv
module sr_clear_driver
  import sr_drv_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int PHASE_CYC = 2,
  parameter int DEB_CYC   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_raw,
  input  logic             upd_req,
  input  logic             clr_req,
  input  logic [WIDTH-1:0] upd_word,
  output logic             busy,
  output logic             ser_out,
  output logic             shclk_out,
  output logic             latch_out,
  output logic             clr_n_out
);
  logic     press;
  logic     next_is_clr_q;
  logic     take_btn, go_clr, go_upd;
  logic [WIDTH-1:0] word_sel;
  pin_set_t pins;

  sr_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk        (clk),
    .rst        (rst),
    .raw_in     (btn_raw),
    .press_pulse(press)
  );

  // Priority: clear strobe, then load strobe, then button press.
  always_comb begin
    take_btn = !busy && press && !clr_req && !upd_req;
    go_clr   = !busy && (clr_req || (take_btn && next_is_clr_q));
    go_upd   = !busy && !clr_req && (upd_req || (take_btn && !next_is_clr_q));
    word_sel = upd_req ? upd_word : {WIDTH{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (rst)           next_is_clr_q <= 1'b1;
    else if (take_btn) next_is_clr_q <= !next_is_clr_q;
  end

  sr_seq_fsm #(.WIDTH(WIDTH), .PHASE_CYC(PHASE_CYC)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .go_upd (go_upd),
    .go_clr (go_clr),
    .word_in(word_sel),
    .pins   (pins),
    .busy   (busy)
  );

  assign ser_out   = pins.ser;
  assign shclk_out = pins.shclk;
  assign latch_out = pins.latch;
  assign clr_n_out = pins.clr_n;
endmodule

// File: rtl/sr_clear_driver_chk.sv
module sr_clear_driver_chk #(
  parameter int PHASE_CYC = 2
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic ser_out,
  input logic shclk_out,
  input logic latch_out,
  input logic clr_n_out
);
  localparam int CW = $clog2(PHASE_CYC + 2);
  localparam logic [CW-1:0] PH = CW'(PHASE_CYC);
  localparam logic [CW-1:0] SAT = CW'(PHASE_CYC + 1);

  logic [CW-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= shclk_out  ? ((hi_cnt == SAT) ? SAT : hi_cnt + 1'b1) : '0;
      lo_cnt <= !clr_n_out ? ((lo_cnt == SAT) ? SAT : lo_cnt + 1'b1) : '0;
    end
  end

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (latch_out && clr_n_out && !shclk_out && !ser_out)); // R1

  AST_LATCH_FALL_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_out) |-> busy); // R2

  AST_CLR_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !clr_n_out |-> (!shclk_out && !ser_out && latch_out)); // R3

  AST_SHCLK_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (!shclk_out && hi_cnt != '0) |-> hi_cnt == PH); // R5

  AST_CLR_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (clr_n_out && lo_cnt != '0) |-> lo_cnt == PH); // R5

  AST_PIN_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!clr_n_out, shclk_out})); // R3
endmodule

bind sr_clear_driver sr_clear_driver_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .ser_out  (ser_out),
  .shclk_out(shclk_out),
  .latch_out(latch_out),
  .clr_n_out(clr_n_out)
);

// File: tb/sr_clear_driver_bench.sv
module sr_clear_driver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 8;
  localparam int PHASE_CYC = 2;
  localparam int DEB_CYC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic upd_req = 1'b0;
  logic clr_req = 1'b0;
  logic [WIDTH-1:0] upd_word = '0;
  logic busy, ser_out, shclk_out, latch_out, clr_n_out;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_clear_driver #(.WIDTH(WIDTH), .PHASE_CYC(PHASE_CYC), .DEB_CYC(DEB_CYC)) u_sr_clear_driver (
    .clk(clk), .rst(rst), .btn_raw(btn_raw), .upd_req(upd_req), .clr_req(clr_req),
    .upd_word(upd_word), .busy(busy), .ser_out(ser_out), .shclk_out(shclk_out),
    .latch_out(latch_out), .clr_n_out(clr_n_out)
  );

  // Model of the external register: async-cleared shift stage, storage on latch rise.
  logic [WIDTH-1:0] m_shift;
  logic [WIDTH-1:0] m_q;
  always @(posedge shclk_out or negedge clr_n_out)
    if (!clr_n_out) m_shift <= '0;
    else            m_shift <= {m_shift[WIDTH-2:0], ser_out};
  always @(posedge latch_out) m_q <= m_shift;

  int sh_rises = 0, clr_falls = 0, busy_rises = 0;
  always @(posedge shclk_out) sh_rises++;
  always @(negedge clr_n_out) clr_falls++;
  always @(posedge busy) busy_rises++;

  int hi_run = 0, last_hi = 0, lo_run = 0, last_clr_lo = 0;
  always @(negedge clk) begin
    if (shclk_out) hi_run++;
    else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end
    if (!clr_n_out) lo_run++;
    else begin
      if (lo_run != 0) last_clr_lo = lo_run;
      lo_run = 0;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
  endtask

  task automatic pulse(input logic do_upd, input logic do_clr, input logic [WIDTH-1:0] w);
    @(negedge clk);
    upd_req = do_upd; clr_req = do_clr; upd_word = w;
    @(negedge clk);
    upd_req = 1'b0; clr_req = 1'b0;
  endtask

  task automatic set_btn(input logic lvl);
    @(negedge clk);
    btn_raw = lvl;
    repeat (DEB_CYC + 8) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && latch_out && clr_n_out && !shclk_out && !ser_out, "R1 idle pins",
          {busy, latch_out, clr_n_out, shclk_out, ser_out}, 5'b01100);
  endtask

  task automatic t_load(input logic [WIDTH-1:0] w);
    int s0;
    s0 = sh_rises;
    pulse(1'b1, 1'b0, w);
    check(busy, "R8 busy after strobe", busy, 1);
    wait_idle();
    check(m_q == w, "R2 load word", m_q, w);
    check(sh_rises - s0 == WIDTH, "R2 shift edges", sh_rises - s0, WIDTH);
    check(last_hi == PHASE_CYC, "R5 shclk high width", last_hi, PHASE_CYC);
  endtask

  task automatic t_clear_hold();
    logic [WIDTH-1:0] old;
    int s0;
    old = m_q;
    s0 = sh_rises;
    pulse(1'b0, 1'b1, '1);
    for (int i = 0; i < 20 && clr_n_out; i++) @(negedge clk);
    check(m_shift == '0, "R4 shift stage cleared", m_shift, 0);
    check(m_q == old, "R4 storage kept during clear", m_q, old);
    wait_idle();
    check(m_q == '0, "R3 storage zero after clear", m_q, 0);
    check(sh_rises == s0, "R3 no shift edges", sh_rises - s0, 0);
    check(last_clr_lo == PHASE_CYC, "R5 clear low width", last_clr_lo, PHASE_CYC);
  endtask

  task automatic t_busy_button();
    int b0;
    pulse(1'b1, 1'b0, 8'h5A);
    repeat (3) @(negedge clk);
    btn_raw = 1'b1;
    wait_idle();
    b0 = busy_rises;
    repeat (30) @(negedge clk);
    check(busy_rises == b0, "R8 press while busy dropped", busy_rises - b0, 0);
    check(m_q == 8'h5A, "R8 word kept", m_q, 8'h5A);
    set_btn(1'b0);
    set_btn(1'b1);
    wait_idle();
    check(m_q == '0, "R7 first accepted press clears", m_q, 0);
  endtask

  task automatic t_toggle();
    int b0;
    b0 = busy_rises;
    set_btn(1'b0);
    check(busy_rises == b0, "R7 release issues nothing", busy_rises - b0, 0);
    set_btn(1'b1);
    wait_idle();
    check(m_q == 8'hFF, "R7 second press loads ones", m_q, 8'hFF);
    set_btn(1'b0);
    set_btn(1'b1);
    wait_idle();
    check(m_q == '0, "R7 third press clears", m_q, 0);
    set_btn(1'b0);
  endtask

  task automatic t_bounce();
    int b0;
    b0 = busy_rises;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); btn_raw = 1'b1;
      repeat (3) @(negedge clk); btn_raw = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (DEB_CYC + 10) @(negedge clk);
    check(busy_rises == b0, "R6 short bounce ignored", busy_rises - b0, 0);
  endtask

  task automatic t_same_cycle();
    int s0;
    t_load(8'h81);
    s0 = sh_rises;
    pulse(1'b1, 1'b1, 8'hFF);
    wait_idle();
    check(m_q == '0, "R9 clear wins over load", m_q, 0);
    check(sh_rises == s0, "R9 no shifting", sh_rises - s0, 0);
  endtask

  task automatic t_strobe_busy();
    int c0;
    c0 = clr_falls;
    pulse(1'b1, 1'b0, 8'h3C);
    repeat (6) @(negedge clk);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    wait_idle();
    check(clr_falls == c0, "R8 clear strobe while busy dropped", clr_falls - c0, 0);
    check(m_q == 8'h3C, "R8 load survives", m_q, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_busy_button();
    set_btn(1'b0);
    t_load(8'hA5);
    t_load(8'h01);
    t_load(8'h80);
    t_clear_hold();
    t_toggle();
    t_bounce();
    t_same_cycle();
    t_strobe_busy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule